// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit sits in the decode stage of a five-stage pipeline and decides, within that stage, whether control flow leaves the sequential path. For a conditional branch on equality it compares the two register operands. For a direct jump it redirects unconditionally. In both cases it forms the target address. It also owns the fetch program counter, which it advances by four, loads with a target, or holds.

The branch operands come from the register file unless a newer value is on its way. When the instruction in the memory stage writes an operand register, that result is bypassed straight into the comparator. When the instruction in the execute stage writes it, the value does not exist yet, so the unit requests a one-cycle stall and issues no redirect. Register 0 never takes part in either path.

A parameter selects the instruction-set flavour. With one branch delay slot, the instruction after a branch always completes and nothing is killed. Without a delay slot, every redirect also kills the instruction that was just fetched into the IF/ID register.

Top module: `dec_branch_unit`

## Requirements
- R1: During and after a synchronous reset, `fetch_pc` equals the parameter `RESET_PC`.
- R2: With `id_valid` high and `id_op` = 1 (equality branch), `redirect` is high exactly when the two resolved operands are equal and no stall is requested.
- R3: The branch target is `id_pc + 4` plus the sign-extended 16-bit offset shifted left by two. An offset of 25 gives `id_pc + 104`.
- R4: With `id_valid` high and `id_op` = 2 (jump), `redirect` is high and never stalls. The target is bits 31..28 of `id_pc + 4`, followed by the 26-bit index, followed by two zero bits.
- R5: An equality branch whose nonzero `id_rs` or `id_rt` equals `ex_wr_reg` while `ex_wr_en` is high drives `stall` high, with `redirect` and `kill_ifid` low.
- R6: An operand whose nonzero register equals `mem_wr_reg` while `mem_wr_en` is high is compared using `mem_wr_data` instead of the register-file value.
- R7: When both the execute and memory stages write an operand register, the execute match wins: the unit stalls rather than bypassing.
- R8: Register 0 as an operand never causes a stall or a bypass. Its register-file value is used.
- R9: On each clock edge out of reset, `fetch_pc` holds while `stall` is high, loads `target` while `redirect` is high, and otherwise advances by 4.
- R10: With `DELAY_SLOT` = 1, `kill_ifid` is never high.
- R11: With `DELAY_SLOT` = 0, `kill_ifid` equals `redirect`.
- R12: With `id_valid` low, or `id_op` equal to 0 or 3, there is no redirect and no stall, whatever the hazard inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_op | input | 2 | 0 none, 1 equality branch, 2 jump, 3 none |
| id_pc | input | XLEN | Address of the instruction in decode |
| id_rs | input | REG_AW | First operand register |
| id_rt | input | REG_AW | Second operand register |
| id_imm | input | IMM_W | Branch word offset |
| id_index | input | XLEN-6 | Jump word index |
| rs_val | input | XLEN | Register-file value for id_rs |
| rt_val | input | XLEN | Register-file value for id_rt |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_wr_reg | input | REG_AW | Its destination |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_wr_reg | input | REG_AW | Its destination |
| mem_wr_data | input | XLEN | Its result, available for bypass |
| fetch_pc | output | XLEN | Registered fetch address |
| redirect | output | 1 | Next PC comes from target |
| target | output | XLEN | Branch or jump destination |
| kill_ifid | output | 1 | Replace the fetched instruction with a no-op |
| stall | output | 1 | Hold fetch and decode one cycle |

## Verification
A wrong hazard decision shows up in the same cycle at `stall` and `redirect`. On the next edge it also shows up at `fetch_pc`, which either skips a hold or freezes when it should not. Any wrong operand selection or target arithmetic shows up at `redirect` or `target` combinationally. It reaches `fetch_pc` one edge later, and every later fetch address stays displaced. The sweep covers every mix of operand registers, including register 0, execute and memory writers, and equal or unequal data. This makes a bad priority or a missing zero-register guard visible within one cycle.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_EQ   = 2'd1,
    BR_JUMP = 2'd2,
    BR_RSVD = 2'd3
  } br_op_e;

  localparam int NUM_OPND = 2;
endpackage

// File: rtl/dbu_operand_src.sv
module dbu_operand_src #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              need_i,
  input  logic [REG_AW-1:0] src_reg_i,
  input  logic [DATA_W-1:0] rf_val_i,
  input  logic              ex_wr_en_i,
  input  logic [REG_AW-1:0] ex_wr_reg_i,
  input  logic              mem_wr_en_i,
  input  logic [REG_AW-1:0] mem_wr_reg_i,
  input  logic [DATA_W-1:0] mem_wr_data_i,
  output logic [DATA_W-1:0] opnd_o,
  output logic              stall_o
);
  logic src_nonzero;
  logic ex_hit;
  logic mem_hit;

  assign src_nonzero = (src_reg_i != '0);
  assign ex_hit  = ex_wr_en_i  && src_nonzero && (ex_wr_reg_i  == src_reg_i);
  assign mem_hit = mem_wr_en_i && src_nonzero && (mem_wr_reg_i == src_reg_i);

  // Execute-stage producer has no value yet: wait one cycle.
  assign stall_o = need_i && ex_hit;
  // Memory-stage producer: take its result ahead of the register file.
  assign opnd_o  = mem_hit ? mem_wr_data_i : rf_val_i;

  // R8: the zero register never holds the pipeline
  a_r8_zero_no_stall: assert property (@(posedge clk) disable iff (rst)
    (src_reg_i == '0) |-> (!stall_o && opnd_o == rf_val_i));

  // R7: an execute-stage writer always forces a stall over the bypass
  a_r7_ex_priority: assert property (@(posedge clk) disable iff (rst)
    (need_i && ex_wr_en_i && mem_wr_en_i && src_nonzero &&
     ex_wr_reg_i == src_reg_i && mem_wr_reg_i == src_reg_i) |-> stall_o);
endmodule

// File: rtl/dbu_resolve.sv
module dbu_resolve
  import dbu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic               valid_i,
  input  br_op_e             op_i,
  input  logic [XLEN-1:0]    opa_i,
  input  logic [XLEN-1:0]    opb_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [XLEN-7:0]    index_i,
  output logic               taken_o,
  output logic [XLEN-1:0]    target_o
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] offset_ext;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  assign pc_next    = pc_i + XLEN'(4);
  assign offset_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign br_target  = pc_next + (offset_ext << 2);
  assign jmp_target = {pc_next[XLEN-1:XLEN-4], index_i, 2'b00};

  always_comb begin
    taken_o  = 1'b0;
    target_o = br_target;
    if (valid_i) begin
      unique case (op_i)
        BR_EQ:   taken_o = (opa_i == opb_i);
        BR_JUMP: begin
          taken_o  = 1'b1;
          target_o = jmp_target;
        end
        default: taken_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dec_branch_unit.sv
module dec_branch_unit
  import dbu_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          REG_AW     = 5,
  parameter int          IMM_W      = 16,
  parameter bit          DELAY_SLOT = 1'b1,
  parameter logic [31:0] RESET_PC   = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [1:0]        id_op,
  input  logic [XLEN-1:0]   id_pc,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [IMM_W-1:0]  id_imm,
  input  logic [XLEN-7:0]   id_index,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic              ex_wr_en,
  input  logic [REG_AW-1:0] ex_wr_reg,
  input  logic              mem_wr_en,
  input  logic [REG_AW-1:0] mem_wr_reg,
  input  logic [XLEN-1:0]   mem_wr_data,
  output logic [XLEN-1:0]   fetch_pc,
  output logic              redirect,
  output logic [XLEN-1:0]   target,
  output logic              kill_ifid,
  output logic              stall
);
  br_op_e op;
  logic   need_opnd;
  logic   taken_raw;

  logic [NUM_OPND-1:0][REG_AW-1:0] src_reg;
  logic [NUM_OPND-1:0][XLEN-1:0]   rf_val;
  logic [NUM_OPND-1:0][XLEN-1:0]   opnd;
  logic [NUM_OPND-1:0]             opnd_stall;

  assign op        = br_op_e'(id_op);
  assign need_opnd = id_valid && (op == BR_EQ);

  assign src_reg[0] = id_rs;
  assign src_reg[1] = id_rt;
  assign rf_val[0]  = rs_val;
  assign rf_val[1]  = rt_val;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    dbu_operand_src #(
      .DATA_W (XLEN),
      .REG_AW (REG_AW)
    ) u_src (
      .clk           (clk),
      .rst           (rst),
      .need_i        (need_opnd),
      .src_reg_i     (src_reg[g]),
      .rf_val_i      (rf_val[g]),
      .ex_wr_en_i    (ex_wr_en),
      .ex_wr_reg_i   (ex_wr_reg),
      .mem_wr_en_i   (mem_wr_en),
      .mem_wr_reg_i  (mem_wr_reg),
      .mem_wr_data_i (mem_wr_data),
      .opnd_o        (opnd[g]),
      .stall_o       (opnd_stall[g])
    );
  end

  dbu_resolve #(
    .XLEN  (XLEN),
    .IMM_W (IMM_W)
  ) u_resolve (
    .valid_i  (id_valid),
    .op_i     (op),
    .opa_i    (opnd[0]),
    .opb_i    (opnd[1]),
    .pc_i     (id_pc),
    .imm_i    (id_imm),
    .index_i  (id_index),
    .taken_o  (taken_raw),
    .target_o (target)
  );

  assign stall    = |opnd_stall;
  assign redirect = taken_raw && !stall;

  if (DELAY_SLOT) begin : g_slot
    assign kill_ifid = 1'b0;
  end else begin : g_noslot
    assign kill_ifid = redirect;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= XLEN'(RESET_PC);
    end else if (stall) begin
      fetch_pc <= fetch_pc;
    end else if (redirect) begin
      fetch_pc <= target;
    end else begin
      fetch_pc <= fetch_pc + XLEN'(4);
    end
  end

  // R9: stall freezes the fetch address
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    stall |=> (fetch_pc == $past(fetch_pc)));

  // R9: a redirect loads the resolved target
  a_r9_load_target: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (fetch_pc == $past(target)));

  // R9: sequential flow otherwise
  a_r9_step: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redirect) |=> (fetch_pc == $past(fetch_pc) + XLEN'(4)));

  // R5: a stall comes only from an equality branch with an execute writer
  a_r5_stall_source: assert property (@(posedge clk) disable iff (rst)
    stall |-> (id_valid && id_op == 2'd1 && ex_wr_en && !redirect));

  // R11: a kill is only ever paired with a redirect
  a_r11_kill_needs_redirect: assert property (@(posedge clk) disable iff (rst)
    kill_ifid |-> redirect);

  // R4: jumps never wait on operands
  a_r4_jump_no_stall: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_op == 2'd2) |-> (redirect && !stall));
endmodule

// File: tb/dec_branch_unit_test.sv
module dec_branch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        id_valid;
  logic [1:0]  id_op;
  logic [31:0] id_pc;
  logic [4:0]  id_rs, id_rt;
  logic [15:0] id_imm;
  logic [25:0] id_index;
  logic [31:0] rs_val, rt_val;
  logic        ex_wr_en, mem_wr_en;
  logic [4:0]  ex_wr_reg, mem_wr_reg;
  logic [31:0] mem_wr_data;

  logic [31:0] pc_a, pc_b, tgt_a, tgt_b;
  logic        rd_a, rd_b, kill_a, kill_b, st_a, st_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_branch_unit #(.DELAY_SLOT(1'b1), .RESET_PC(RST_PC)) uut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_op(id_op), .id_pc(id_pc),
    .id_rs(id_rs), .id_rt(id_rt), .id_imm(id_imm), .id_index(id_index),
    .rs_val(rs_val), .rt_val(rt_val), .ex_wr_en(ex_wr_en), .ex_wr_reg(ex_wr_reg),
    .mem_wr_en(mem_wr_en), .mem_wr_reg(mem_wr_reg), .mem_wr_data(mem_wr_data),
    .fetch_pc(pc_a), .redirect(rd_a), .target(tgt_a), .kill_ifid(kill_a), .stall(st_a));

  dec_branch_unit #(.DELAY_SLOT(1'b0), .RESET_PC(RST_PC)) uut_nds (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_op(id_op), .id_pc(id_pc),
    .id_rs(id_rs), .id_rt(id_rt), .id_imm(id_imm), .id_index(id_index),
    .rs_val(rs_val), .rt_val(rt_val), .ex_wr_en(ex_wr_en), .ex_wr_reg(ex_wr_reg),
    .mem_wr_en(mem_wr_en), .mem_wr_reg(mem_wr_reg), .mem_wr_data(mem_wr_data),
    .fetch_pc(pc_b), .redirect(rd_b), .target(tgt_b), .kill_ifid(kill_b), .stall(st_b));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_pc(input int k);
    case (k % 4)
      0: pick_pc = 32'h0040_0100;
      1: pick_pc = 32'h0FFF_FFFC;
      2: pick_pc = 32'hF123_4560;
      default: pick_pc = 32'h7FFF_FFF8;
    endcase
  endfunction

  function automatic logic [15:0] pick_imm(input int k);
    case (k % 4)
      0: pick_imm = 16'd25;
      1: pick_imm = 16'hFFFF;
      2: pick_imm = 16'h8000;
      default: pick_imm = 16'h7FFF;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_pc;
    int k;
    rst = 1'b1; id_valid = 0; id_op = 0; id_pc = 0; id_rs = 0; id_rt = 0;
    id_imm = 0; id_index = 0; rs_val = 0; rt_val = 0; ex_wr_en = 0;
    ex_wr_reg = 0; mem_wr_en = 0; mem_wr_reg = 0; mem_wr_data = 0;
    repeat (3) @(negedge clk);
    check("R1", "fetch_pc in reset", pc_a, RST_PC);
    rst = 1'b0;
    exp_pc = RST_PC;
    check("R1", "fetch_pc after reset", pc_b, RST_PC);
    k = 0;
    for (int op = 0; op < 4; op++)
    for (int v = 0; v < 2; v++)
    for (int rs = 0; rs < 3; rs++)
    for (int rt = 0; rt < 3; rt++)
    for (int ee = 0; ee < 2; ee++)
    for (int er = 0; er < 3; er++)
    for (int me = 0; me < 2; me++)
    for (int mr = 0; mr < 3; mr++)
    for (int p = 0; p < 4; p++) begin
      logic ex_s, ex_t, me_s, me_t, e_stall, e_taken, is_beq, is_j;
      logic [31:0] a, b, e_tgt, pc4;
      string tag;
      if (op == 3 && (rs + rt + er + mr) > 2) continue;
      id_valid = v[0]; id_op = op[1:0]; id_rs = rs[4:0]; id_rt = rt[4:0];
      ex_wr_en = ee[0]; ex_wr_reg = er[4:0]; mem_wr_en = me[0]; mem_wr_reg = mr[4:0];
      id_pc = pick_pc(k); id_imm = pick_imm(k / 3);
      id_index = 26'h2AB_CDEF ^ 26'(k * 7919);
      rs_val = 32'hA5A5_0000 + 32'(k);
      rt_val = p[0] ? rs_val : ~rs_val;
      mem_wr_data = p[1] ? rs_val : 32'h3C3C_3C3C;
      k++;
      is_beq = v[0] && op == 1;
      is_j   = v[0] && op == 2;
      ex_s = ee[0] && er != 0 && er == rs;
      ex_t = ee[0] && er != 0 && er == rt;
      me_s = me[0] && mr != 0 && mr == rs;
      me_t = me[0] && mr != 0 && mr == rt;
      e_stall = is_beq && (ex_s || ex_t);
      a = me_s ? mem_wr_data : rs_val;
      b = me_t ? mem_wr_data : rt_val;
      e_taken = !e_stall && (is_j || (is_beq && a == b));
      pc4 = id_pc + 32'd4;
      e_tgt = is_j ? {pc4[31:28], id_index, 2'b00}
                   : pc4 + ({{16{id_imm[15]}}, id_imm} << 2);
      if (is_j) tag = "R4";
      else if (!is_beq) tag = "R12";
      else if (e_stall && (me_s || me_t)) tag = "R7";
      else if (e_stall) tag = "R5";
      else if (me_s || me_t) tag = "R6";
      else if ((rs == 0 || rt == 0) && (ee || me)) tag = "R8";
      else tag = "R2";
      #1;
      check(tag, "redirect", {31'd0, rd_a}, {31'd0, e_taken});
      check(tag, "stall", {31'd0, st_a}, {31'd0, e_stall});
      check("R10", "kill delay-slot mode", {31'd0, kill_a}, 32'd0);
      check("R11", "kill no-slot mode", {31'd0, kill_b}, {31'd0, e_taken});
      if (e_taken) check(is_j ? "R4" : "R3", "target", tgt_b, e_tgt);
      if (e_stall) exp_pc = exp_pc;
      else if (e_taken) exp_pc = e_tgt;
      else exp_pc = exp_pc + 32'd4;
      @(negedge clk);
      check("R9", "fetch_pc", pc_a, exp_pc);
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule